// File: doc/BRIEF.md
# Byte-Lane Static RAM Pin Emulator

This block stands in for an asynchronous 16-bit static RAM with two byte lanes when a memory controller is tested. It accepts the usual memory pins: an address, an active-low select and an active-high select, an active-low write strobe, an active-low output strobe and one active-low strobe per byte lane. It returns read data together with a separate drive enable for each lane, so the surrounding logic never needs a tri-state net. Storage is a small array of words whose depth is a parameter. Address bits above that depth fold onto the same words.

All pin decoding is combinational, so read data and drive enables follow the pins within the same cycle. A write lasts as long as both selects are active and the write strobe is low. When that window closes, the block commits the address, data and lane strobes captured at the last clock edge inside the window, and it commits them on the next edge. The block also acts as a protocol monitor. It raises a sticky flag when the modelled address moves while a write window is open.

Top module: `sram_emu`

## Requirements
- R1: When `ce_n_i` is 1 or `ce2_i` is 0, `dout_en_o` is 2'b00 whatever the other inputs are.
- R2: When both selects are active and both `lb_n_i` and `ub_n_i` are 1, `dout_en_o` is 2'b00.
- R3: When both selects are active, `we_n_i` is 1 and `oe_n_i` is 1, `dout_en_o` is 2'b00.
- R4: When both selects are active, `we_n_i` is 1 and `oe_n_i` is 0, bit 0 of `dout_en_o` equals the inverse of `lb_n_i` and bit 1 equals the inverse of `ub_n_i`. An enabled lane shows the stored byte of the addressed word on the same cycle: lane 0 is `dout_o[7:0]` and lane 1 is `dout_o[15:8]`. A disabled lane reads as zero.
- R5: When both selects are active and `we_n_i` is 0, `dout_en_o` is 2'b00 and `oe_n_i` has no effect.
- R6: A write window is open while both selects are active and `we_n_i` is 0. The window can be closed by raising `we_n_i`, raising `ce_n_i` or lowering `ce2_i`. On the first clock edge at which the window is seen closed, the address, data and strobes sampled at the previous edge are committed. The new data is visible only after that edge.
- R7: A commit writes only the lanes whose sampled strobe was 0. A lane whose strobe was 1 keeps its old byte, and a write with both strobes at 1 changes nothing.
- R8: `viol_o` sets on a clock edge at which the window is open, was also open at the previous edge, and the modelled address differs from the one sampled at that previous edge. Once set, it stays set until reset.
- R9: Address bits at and above log2(DEPTH) are ignored. They alias onto the same word, and changing only those bits during a write does not set `viol_o`.
- R10: A synchronous active-low reset clears `viol_o` and sets every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Word address |
| ce_n_i | input | 1 | Select, active low |
| ce2_i | input | 1 | Select, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output strobe, active low |
| lb_n_i | input | 1 | Lane 0 (bits 7:0) strobe, active low |
| ub_n_i | input | 1 | Lane 1 (bits 15:8) strobe, active low |
| din_i | input | 16 | Write data |
| dout_o | output | 16 | Read data, zero on disabled lanes |
| dout_en_o | output | 2 | Per-lane drive enable |
| viol_o | output | 1 | Sticky address-change-during-write flag |

## Verification
Drive enables and read data are combinational. The bench therefore sets the pins at a falling edge and compares the outputs 1 ns later, in the same cycle. A write needs two rising edges: the first samples the window and the second commits it. The bench checks old data in the low phase between those edges and new data only after the second edge. The violation flag is registered, so it is compared at the falling edge after the rising edge that saw the moved address. The control pins are swept through all 64 combinations, and every word is written and read back under each strobe pattern.

// File: rtl/sram_emu_pkg.sv
// Shared types for the static RAM pin emulator.
// Assumes byte lanes of eight bits each.
package sram_emu_pkg;

    localparam int LANE_BITS = 8;

    // Decoded bus state for one cycle of pin values.
    typedef enum logic [1:0] {
        BUS_DESEL = 2'd0,
        BUS_QUIET = 2'd1,
        BUS_READ  = 2'd2,
        BUS_WRITE = 2'd3
    } bus_mode_e;

endpackage

// File: rtl/sram_emu_decode.sv
// Pin decoder: turns the select, strobe and lane pins into a bus mode,
// a write-window indication and per-lane drive enables.
// Assumes all pins are active low except ce2.
module sram_emu_decode
    import sram_emu_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] strb_n,
    output bus_mode_e        mode,
    output logic             wr_window,
    output logic [LANES-1:0] lane_oe
);

    logic selected;
    logic any_lane;

    assign selected = ~ce_n & ce2;
    assign any_lane = ~(&strb_n);

    // Mode priority: selects, then lane strobes, then write, then output strobe.
    always_comb begin
        if (!selected)      mode = BUS_DESEL;
        else if (!any_lane) mode = BUS_QUIET;
        else if (!we_n)     mode = BUS_WRITE;
        else if (!oe_n)     mode = BUS_READ;
        else                mode = BUS_QUIET;
    end

    // A write window needs only both selects and the write strobe.
    assign wr_window = selected & ~we_n;

    // Drive only the lanes whose strobe is low, and only in read mode.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane_oe
            assign lane_oe[l] = (mode == BUS_READ) & ~strb_n[l];
        end
    endgenerate

endmodule

// File: rtl/sram_emu_wrtrack.sv
// Write tracker: samples the write window, address, data and strobes at
// each edge, raises a one-cycle commit when an open window closes, and
// keeps a sticky flag for an address move inside a window.
// Assumes the window is taken from the pins as decoded in the same cycle.
module sram_emu_wrtrack #(
    parameter int IW    = 6,
    parameter int LANES = 2,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_window,
    input  logic [IW-1:0]    idx,
    input  logic [DW-1:0]    din,
    input  logic [LANES-1:0] strb_n,
    output logic             commit,
    output logic [IW-1:0]    c_idx,
    output logic [DW-1:0]    c_data,
    output logic [LANES-1:0] c_strb_n,
    output logic             viol
);

    logic win_q;
    logic moved;

    // Capture window state and payload every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= 1'b0;
            c_idx    <= '0;
            c_data   <= '0;
            c_strb_n <= '1;
        end else begin
            win_q    <= wr_window;
            c_idx    <= idx;
            c_data   <= din;
            c_strb_n <= strb_n;
        end
    end

    assign commit = win_q & ~wr_window;
    assign moved  = win_q & wr_window & (idx != c_idx);

    // Sticky protocol flag, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)     viol <= 1'b0;
        else if (moved) viol <= 1'b1;
    end

    p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);

    p_viol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(wr_window));

endmodule

// File: rtl/sram_emu_store.sv
// Word store split into byte lanes; each lane is written on commit when
// its sampled strobe is low, and read combinationally at any index.
// Assumes DEPTH is a power of two so every index is in range.
module sram_emu_store
    import sram_emu_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LANES = 2,
    parameter int IW    = $clog2(DEPTH),
    parameter int DW    = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IW-1:0]    w_idx,
    input  logic [DW-1:0]    w_data,
    input  logic [LANES-1:0] w_strb_n,
    input  logic [IW-1:0]    r_idx,
    output logic [DW-1:0]    r_data
);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_BITS-1:0] cells [DEPTH];

            // Clear on reset, otherwise write the committed byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
                end else if (commit && !w_strb_n[l]) begin
                    cells[w_idx] <= w_data[l*LANE_BITS +: LANE_BITS];
                end
            end

            assign r_data[l*LANE_BITS +: LANE_BITS] = cells[r_idx];
        end
    endgenerate

endmodule

// File: rtl/sram_emu.sv
// Top of the static RAM pin emulator: decodes the pins, tracks write
// windows, holds the words and drives per-lane data with enables.
// Assumes two byte lanes and an address wider than the modelled index.
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int AW    = 17,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          ce_n_i,
    input  logic          ce2_i,
    input  logic          we_n_i,
    input  logic          oe_n_i,
    input  logic          lb_n_i,
    input  logic          ub_n_i,
    input  logic [15:0]   din_i,
    output logic [15:0]   dout_o,
    output logic [1:0]    dout_en_o,
    output logic          viol_o
);

    localparam int LANES = 2;
    localparam int DW    = LANES * LANE_BITS;
    localparam int IW    = $clog2(DEPTH);

    bus_mode_e        mode;
    logic             wr_window;
    logic [LANES-1:0] strb_n;
    logic [LANES-1:0] lane_oe;
    logic [IW-1:0]    idx;
    logic             commit;
    logic [IW-1:0]    c_idx;
    logic [DW-1:0]    c_data;
    logic [LANES-1:0] c_strb_n;
    logic [DW-1:0]    r_data;
    logic             unused_addr_hi;

    assign strb_n         = {ub_n_i, lb_n_i};
    assign idx            = addr_i[IW-1:0];
    assign unused_addr_hi = ^addr_i[AW-1:IW];

    sram_emu_decode #(.LANES(LANES)) u_decode (
        .ce_n      (ce_n_i),
        .ce2       (ce2_i),
        .we_n      (we_n_i),
        .oe_n      (oe_n_i),
        .strb_n    (strb_n),
        .mode      (mode),
        .wr_window (wr_window),
        .lane_oe   (lane_oe)
    );

    sram_emu_wrtrack #(.IW(IW), .LANES(LANES), .DW(DW)) u_wrtrack (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_window (wr_window),
        .idx       (idx),
        .din       (din_i),
        .strb_n    (strb_n),
        .commit    (commit),
        .c_idx     (c_idx),
        .c_data    (c_data),
        .c_strb_n  (c_strb_n),
        .viol      (viol_o)
    );

    sram_emu_store #(.DEPTH(DEPTH), .LANES(LANES), .IW(IW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .w_idx    (c_idx),
        .w_data   (c_data),
        .w_strb_n (c_strb_n),
        .r_idx    (idx),
        .r_data   (r_data)
    );

    // Mask read data per lane so undriven lanes read as zero.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_out
            assign dout_o[l*LANE_BITS +: LANE_BITS] =
                lane_oe[l] ? r_data[l*LANE_BITS +: LANE_BITS] : '0;
        end
    endgenerate

    assign dout_en_o = lane_oe;

    p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n_i || !ce2_i) |-> (dout_en_o == 2'b00));

    p_strobe_gates_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en_o & {ub_n_i, lb_n_i}) == 2'b00);

    p_no_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_i |-> (dout_en_o == 2'b00));

    p_out_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (dout_en_o == 2'b00));

endmodule

// File: tb/sram_emu_test.sv
`timescale 1ns/1ps
module sram_emu_test;

    localparam int AW    = 17;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, ce2, we_n, oe_n, lb_n, ub_n;
    logic [15:0]   din;
    logic [15:0]   dout;
    logic [1:0]    dout_en;
    logic          viol;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model [DEPTH];

    always #2.5 clk = ~clk;

    sram_emu #(.AW(AW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .ce2_i(ce2),
        .we_n_i(we_n), .oe_n_i(oe_n), .lb_n_i(lb_n), .ub_n_i(ub_n),
        .din_i(din), .dout_o(dout), .dout_en_o(dout_en), .viol_o(viol)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce_n = 1'b1; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    endtask

    // Read through the pins and compare against the bench's own model.
    task automatic read_chk(input string req, input logic [AW-1:0] a,
                            input logic lb, input logic ub, input logic oe);
        logic [1:0]  en_e;
        logic [15:0] d_e;
        @(negedge clk);
        ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = oe; lb_n = lb; ub_n = ub; addr = a;
        #1;
        en_e = oe ? 2'b00 : {~ub, ~lb};
        d_e  = model[a[5:0]] & {{8{en_e[1]}}, {8{en_e[0]}}};
        check(req, {30'd0, dout_en}, {30'd0, en_e});
        check(req, {16'd0, dout}, {16'd0, d_e});
    endtask

    // One write window; end_kind 0 raises we_n, 1 raises ce_n, 2 lowers ce2.
    task automatic write_win(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic lb, input logic ub, input int end_kind);
        @(negedge clk);
        ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = 1'b0; lb_n = lb; ub_n = ub;
        addr = a; din = d;
        @(negedge clk);
        if (end_kind == 0)      we_n = 1'b1;
        else if (end_kind == 1) ce_n = 1'b1;
        else                    ce2  = 1'b0;
        @(posedge clk);
        if (!lb) model[a[5:0]][7:0]  = d[7:0];
        if (!ub) model[a[5:0]][15:8] = d[15:8];
        go_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; addr = '0; din = '0;
        ce_n = 1'b1; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset state
        check("R10 flag", {31'd0, viol}, 32'd0);
        for (int a = 0; a < DEPTH; a++) read_chk("R10 zero word", AW'(a), 1'b0, 1'b0, 1'b0);

        // R6: word writes with each way of closing the window
        for (int a = 0; a < DEPTH; a++)
            write_win(AW'(a), 16'((a * 16'h0123) ^ 16'h5AA5), 1'b0, 1'b0, a % 3);

        // R4, R2, R3: read every word with every strobe pattern
        for (int a = 0; a < DEPTH; a++) begin
            for (int s = 0; s < 4; s++) read_chk("R4 lane read", AW'(a), s[0], s[1], 1'b0);
            read_chk("R3 oe high", AW'(a), 1'b0, 1'b0, 1'b1);
        end

        // R6: not visible before the commit edge, visible after it
        @(negedge clk);
        ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        addr = AW'(5); din = 16'hBEEF; oe_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        #1;
        check("R6 old data before commit", {16'd0, dout}, {16'd0, model[5]});
        @(negedge clk);
        #1;
        check("R6 new data after commit", {16'd0, dout}, 32'h0000BEEF);
        model[5] = 16'hBEEF;
        go_idle();

        // R7: byte lanes alone, and a write with no lane selected
        for (int a = 3; a < DEPTH; a += 7) begin
            write_win(AW'(a), 16'hC3A0 + 16'(a), 1'b0, 1'b1, 0);
            read_chk("R7 low lane only", AW'(a), 1'b0, 1'b0, 1'b0);
            write_win(AW'(a), 16'h1E00 + 16'(a), 1'b1, 1'b0, 0);
            read_chk("R7 high lane only", AW'(a), 1'b0, 1'b0, 1'b0);
            write_win(AW'(a), 16'hFFFF, 1'b1, 1'b1, 0);
            read_chk("R7 no lane written", AW'(a), 1'b0, 1'b0, 1'b0);
        end

        // R1, R2, R3, R5: sweep all control pin combinations at one word
        for (int c = 0; c < 64; c++) begin
            logic sel;
            logic [1:0] en_e;
            @(negedge clk);
            addr = AW'(9); din = model[9];
            ce_n = c[0]; ce2 = c[1]; we_n = c[2]; oe_n = c[3]; lb_n = c[4]; ub_n = c[5];
            #1;
            sel  = ~c[0] & c[1];
            en_e = (sel && c[2] && !c[3]) ? {~c[5], ~c[4]} : 2'b00;
            if (!sel)            check("R1 deselected", {30'd0, dout_en}, {30'd0, en_e});
            else if (c[4] && c[5]) check("R2 no strobe", {30'd0, dout_en}, {30'd0, en_e});
            else if (!c[2])      check("R5 write mode", {30'd0, dout_en}, {30'd0, en_e});
            else                 check("R3 R4 read mode", {30'd0, dout_en}, {30'd0, en_e});
        end
        go_idle();
        read_chk("R5 word kept after sweep", AW'(9), 1'b0, 1'b0, 1'b0);

        // R9: upper bits alias and do not trip the flag
        write_win({11'h5A3, 6'd12}, 16'h7E81, 1'b0, 1'b0, 0);
        read_chk("R9 alias read", AW'(12), 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        addr = {11'h001, 6'd20}; din = 16'h2468;
        @(negedge clk);
        addr = {11'h7FF, 6'd20};
        @(negedge clk);
        we_n = 1'b1;
        @(posedge clk);
        model[20] = 16'h2468;
        go_idle();
        check("R9 no flag on upper bits", {31'd0, viol}, 32'd0);
        read_chk("R9 aliased write", AW'(20), 1'b0, 1'b0, 1'b0);

        // R8: address move inside a window sets a sticky flag
        check("R8 flag clear before", {31'd0, viol}, 32'd0);
        @(negedge clk);
        ce_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
        addr = AW'(30); din = 16'h0F0F;
        @(negedge clk);
        #1;
        check("R8 flag clear one edge in", {31'd0, viol}, 32'd0);
        addr = AW'(31);
        @(negedge clk);
        check("R8 flag set", {31'd0, viol}, 32'd1);
        we_n = 1'b1;
        @(posedge clk);
        model[31] = 16'h0F0F;
        go_idle();
        repeat (4) @(negedge clk);
        check("R8 flag sticky", {31'd0, viol}, 32'd1);
        read_chk("R8 last address committed", AW'(31), 1'b0, 1'b0, 1'b0);
        read_chk("R8 first address untouched", AW'(30), 1'b0, 1'b0, 1'b0);

        // R10: reset again clears flag and words
        go_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
        check("R10 flag after reset", {31'd0, viol}, 32'd0);
        read_chk("R10 word cleared", AW'(31), 1'b0, 1'b0, 1'b0);
        read_chk("R10 word cleared", AW'(5), 1'b0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule